// File: doc/BRIEF.md
# Servo Memory and Status Access Port

This block gives a host command stream single-port access to the memories of a multi-channel feedback servo. Each command carries one address word and one data word. The top address bit says whether the access is a write. Two bits below it pick one of three places: the per-profile coefficient memory, the filter state memory, or the configuration and status register. A write lands in one cycle. A read returns one data word on the following cycle, marked by a valid strobe.

The block owns the coefficient RAM. The filter engine reads that RAM through its own synchronous port. The block also owns the state RAM, whose entries are 25 bits wide and signed. The engine reads and writes the full width of an entry. The host sees only the 18 most significant bits of an entry.

The configuration register holds the servo enable. The status word reports three things: that enable, the engine's cycle-done flag, and one sticky clip flag per channel. A status read returns the clip flags and clears them all in the same step. A clip event that arrives in the same cycle as that read survives the clear.

Top module: `servo_mem_port`

## Requirements
- R1: Address bit 12 set makes a command a write. With bit 12 clear, the command is a read and leaves every memory and register unchanged, whatever its data word holds.
- R2: With bit 11 clear, address bits 10:8 give the channel, bits 7:3 the profile and bits 2:0 the word. The resulting 2048 coefficient words are 18 bits each and hold independent values.
- R3: A read command raises rd_valid on the next cycle, with rd_data holding the addressed word. A write command leaves rd_valid low on the next cycle.
- R4: With bit 11 set and bit 10 clear, address bits 8:0 index a 25-bit state entry. A host write stores its 18 data bits as entry bits 24:7 and clears bits 6:0. A host read returns entry bits 24:7.
- R5: The engine state port uses the same 9-bit index as the host. Output state sits at (channel << 5) | profile, and the input sample of channel n sits at 256 | (n << 1). The engine reads the full 25 bits one cycle after it presents the index, and writes the full 25 bits.
- R6: If the engine writes state in the same cycle as a host state write, the engine write is stored and the host write is dropped.
- R7: With bits 11 and 10 both set, a write loads data bit 0 into the enable output.
- R8: A status read, which uses the same address with bit 12 clear, returns enable in bit 0, done in bit 1 and the eight clip flags in bits 15:8. All other bits read as zero.
- R9: A set bit of clip_set in any cycle makes that channel's clip flag stay set. A status read returns the flags and then clears all of them.
- R10: A clip_set bit that coincides with a status read is not reported by that read. It stays set and is reported by the next status read.
- R11: After reset, enable is 0, every clip flag is 0 and rd_valid is 0.
- R12: The engine coefficient port returns the coefficient word at eng_co_addr one cycle after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Host command strobe |
| cmd_addr | input | 13 | Write bit, region select bits and region address |
| cmd_wdata | input | 18 | Host write data |
| rd_valid | output | 1 | Read data strobe, one cycle after a read |
| rd_data | output | 18 | Read data |
| eng_co_addr | input | 11 | Engine coefficient read address |
| eng_co_rdata | output | 18 | Engine coefficient read data |
| eng_st_raddr | input | 9 | Engine state read index |
| eng_st_rdata | output | 25 | Engine state read data |
| eng_st_we | input | 1 | Engine state write enable |
| eng_st_waddr | input | 9 | Engine state write index |
| eng_st_wdata | input | 25 | Engine state write data |
| clip_set | input | 8 | Per-channel clip event pulses |
| done | input | 1 | Engine cycle-done flag |
| enable | output | 1 | Servo enable |

## Verification
A decode fault shows at the ports as one address aliasing onto another: a read returns a value written to a different coefficient or state location. An exhaustive write-then-read sweep exposes it on the first affected address. A fault in the state bit alignment shows on a single read from either side as a shifted or nonzero low field. A fault in the clip flags shows within two status reads, either as a flag that will not clear or as a coincident event that is lost. A stuck enable shows on the first status read after a configuration write.

// File: rtl/servo_mem_port.sv
module servo_mem_port #(
  parameter int CH_W   = 3,
  parameter int PROF_W = 5,
  parameter int WORD_W = 3,
  parameter int COEF_W = 18,
  parameter int ST_W   = 25
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              cmd_valid,
  input  logic [CH_W+PROF_W+WORD_W+1:0]     cmd_addr,
  input  logic [COEF_W-1:0]                 cmd_wdata,
  output logic                              rd_valid,
  output logic [COEF_W-1:0]                 rd_data,
  input  logic [CH_W+PROF_W+WORD_W-1:0]     eng_co_addr,
  output logic [COEF_W-1:0]                 eng_co_rdata,
  input  logic [CH_W+PROF_W:0]              eng_st_raddr,
  output logic [ST_W-1:0]                   eng_st_rdata,
  input  logic                              eng_st_we,
  input  logic [CH_W+PROF_W:0]              eng_st_waddr,
  input  logic [ST_W-1:0]                   eng_st_wdata,
  input  logic [(1<<CH_W)-1:0]              clip_set,
  input  logic                              done,
  output logic                              enable
);
  localparam int CO_AW    = CH_W + PROF_W + WORD_W;
  localparam int CO_DEPTH = 1 << CO_AW;
  localparam int ST_AW    = CH_W + PROF_W + 1;
  localparam int ST_DEPTH = 1 << ST_AW;
  localparam int NCH      = 1 << CH_W;
  localparam int LOW_W    = ST_W - COEF_W;

  logic [COEF_W-1:0] coef_mem [CO_DEPTH];
  logic [ST_W-1:0]   st_mem   [ST_DEPTH];
  logic [NCH-1:0]    clip_q;

  wire wr_bit  = cmd_addr[CO_AW+1];
  wire sel_st  = cmd_addr[CO_AW];
  wire sel_cfg = cmd_addr[CO_AW] & cmd_addr[CO_AW-1];
  wire [CO_AW-1:0] co_idx = cmd_addr[CO_AW-1:0];
  wire [ST_AW-1:0] st_idx = cmd_addr[ST_AW-1:0];

  wire host_rd   = cmd_valid & ~wr_bit;
  wire host_wr   = cmd_valid &  wr_bit;
  wire co_wr     = host_wr & ~sel_st;
  wire st_wr     = host_wr &  sel_st & ~sel_cfg;
  wire cfg_wr    = host_wr &  sel_cfg;
  wire status_rd = host_rd &  sel_cfg;

  wire [COEF_W-1:0] status_w =
    COEF_W'({clip_q, {(8-2){1'b0}}, done, enable});

  always_ff @(posedge clk) begin
    if (co_wr) coef_mem[co_idx] <= cmd_wdata;
    eng_co_rdata <= coef_mem[eng_co_addr];
  end

  always_ff @(posedge clk) begin
    if (eng_st_we)  st_mem[eng_st_waddr] <= eng_st_wdata;
    else if (st_wr) st_mem[st_idx] <= {cmd_wdata, {LOW_W{1'b0}}};
    eng_st_rdata <= st_mem[eng_st_raddr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      enable <= 1'b0;
      clip_q <= '0;
    end else begin
      if (cfg_wr) enable <= cmd_wdata[0];
      clip_q <= (status_rd ? '0 : clip_q) | clip_set;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= host_rd;
      if (host_rd) begin
        if (sel_cfg)     rd_data <= status_w;
        else if (sel_st) rd_data <= st_mem[st_idx][ST_W-1 -: COEF_W];
        else             rd_data <= coef_mem[co_idx];
      end
    end
  end

  AST_READ_STROBE: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !cmd_addr[CO_AW+1]) |=> rd_valid); // R3
  AST_WRITE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_addr[CO_AW+1]) |=> !rd_valid); // R3
  AST_ENABLE_LOAD: assert property (@(posedge clk) disable iff (rst)
    cfg_wr |=> (enable == $past(cmd_wdata[0]))); // R7
  AST_CLIP_STICKY: assert property (@(posedge clk) disable iff (rst)
    (|clip_set) |=> ((clip_q & $past(clip_set)) == $past(clip_set))); // R10
  AST_CLIP_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (status_rd && clip_set == '0) |=> (clip_q == '0)); // R9
  AST_STATUS_FMT: assert property (@(posedge clk) disable iff (rst)
    status_rd |=> (rd_data[7:2] == '0)); // R8
endmodule

// File: tb/servo_mem_port_tb.sv
module servo_mem_port_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_valid = 1'b0;
  logic [12:0] cmd_addr = '0;
  logic [17:0] cmd_wdata = '0;
  logic rd_valid;
  logic [17:0] rd_data;
  logic [10:0] eng_co_addr = '0;
  logic [17:0] eng_co_rdata;
  logic [8:0] eng_st_raddr = '0;
  logic [24:0] eng_st_rdata;
  logic eng_st_we = 1'b0;
  logic [8:0] eng_st_waddr = '0;
  logic [24:0] eng_st_wdata = '0;
  logic [7:0] clip_set = '0;
  logic done = 1'b0;
  logic enable;

  int vectors = 0;
  int errors = 0;
  logic [7:0]  pend_clip = '0;
  logic        pend_ewe = 1'b0;
  logic [8:0]  pend_ewa = '0;
  logic [24:0] pend_ewd = '0;
  logic [17:0] got;
  logic        gotv;

  localparam logic [12:0] WR  = 13'h1000;
  localparam logic [12:0] ST  = 13'h0800;
  localparam logic [12:0] CFG = 13'h0C00;

  always #10 clk = ~clk;

  servo_mem_port u_dut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_addr(cmd_addr),
    .cmd_wdata(cmd_wdata), .rd_valid(rd_valid), .rd_data(rd_data),
    .eng_co_addr(eng_co_addr), .eng_co_rdata(eng_co_rdata),
    .eng_st_raddr(eng_st_raddr), .eng_st_rdata(eng_st_rdata),
    .eng_st_we(eng_st_we), .eng_st_waddr(eng_st_waddr),
    .eng_st_wdata(eng_st_wdata), .clip_set(clip_set), .done(done),
    .enable(enable));

  function automatic logic [17:0] cf(int a);
    return 18'((a * 1237 + 91) & 32'h3ffff);
  endfunction
  function automatic logic [17:0] sf(int a);
    return 18'((a * 733 + 17) & 32'h3ffff);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  endtask

  task automatic cmd(logic [12:0] addr, logic [17:0] data);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_addr = addr; cmd_wdata = data;
    clip_set = pend_clip; eng_st_we = pend_ewe;
    eng_st_waddr = pend_ewa; eng_st_wdata = pend_ewd;
    @(negedge clk);
    cmd_valid = 1'b0; clip_set = '0; eng_st_we = 1'b0;
    pend_clip = '0; pend_ewe = 1'b0;
    gotv = rd_valid; got = rd_data;
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R11 rd_valid", 32'(rd_valid), 0);
    check("R11 enable", 32'(enable), 0);
    rst = 1'b0;
    cmd(CFG, '0);
    check("R11 status after reset", 32'(got), 0);

    for (int a = 0; a < 2048; a++) begin
      cmd(WR | 13'(a), cf(a));
      if (a < 4) check("R3 no strobe on write", 32'(gotv), 0);
    end
    for (int a = 0; a < 2048; a++) begin
      cmd(13'(a), 18'h2AAAA);
      check("R2 coefficient readback", 32'(got), 32'(cf(a)));
      if (a < 4) check("R3 read strobe", 32'(gotv), 1);
    end
    cmd(13'd7, 18'h155);
    check("R1 read leaves word intact", 32'(got), 32'(cf(7)));

    for (int a = 0; a < 2048; a += 37) begin
      @(negedge clk); eng_co_addr = 11'(a);
      @(negedge clk);
      check("R12 engine coefficient read", 32'(eng_co_rdata), 32'(cf(a)));
    end

    for (int i = 0; i < 512; i++) cmd(WR | ST | 13'(i), sf(i));
    for (int i = 0; i < 512; i++) begin
      cmd(ST | 13'(i), '0);
      check("R4 state readback", 32'(got), 32'(sf(i)));
    end
    for (int i = 0; i < 512; i += 29) begin
      @(negedge clk); eng_st_raddr = 9'(i);
      @(negedge clk);
      check("R4 R5 engine sees MSB-aligned", 32'(eng_st_rdata), 32'({sf(i), 7'b0}));
    end
    @(negedge clk);
    eng_st_we = 1'b1; eng_st_waddr = 9'h105; eng_st_wdata = 25'h1ABCDEF;
    @(negedge clk);
    eng_st_we = 1'b0;
    cmd(ST | 13'h105, '0);
    check("R5 host reads engine sample MSBs", 32'(got), 32'(25'h1ABCDEF >> 7));
    eng_st_raddr = 9'h105;
    @(negedge clk); @(negedge clk);
    check("R5 engine reads full width", 32'(eng_st_rdata), 32'h1ABCDEF);

    pend_ewe = 1'b1; pend_ewa = 9'h044; pend_ewd = 25'h0F0F0F0;
    cmd(WR | ST | 13'h044, 18'h3FFFF);
    cmd(ST | 13'h044, '0);
    check("R6 engine write wins", 32'(got), 32'(25'h0F0F0F0 >> 7));

    cmd(WR | CFG, 18'h1);
    check("R7 enable set", 32'(enable), 1);
    done = 1'b1;
    cmd(CFG, '0);
    check("R8 status enable and done", 32'(got), 32'h3);
    cmd(WR | CFG, 18'h2);
    check("R7 enable cleared", 32'(enable), 0);
    done = 1'b0;

    @(negedge clk); clip_set = 8'h25;
    @(negedge clk); clip_set = '0;
    cmd(CFG, '0);
    check("R9 clip flags reported", 32'(got), 32'h2500);
    cmd(CFG, '0);
    check("R9 clip flags cleared", 32'(got), 32'h0);

    @(negedge clk); clip_set = 8'h01;
    @(negedge clk); clip_set = '0;
    pend_clip = 8'h80;
    cmd(CFG, '0);
    check("R10 read shows earlier flag only", 32'(got), 32'h0100);
    cmd(CFG, '0);
    check("R10 coincident flag retained", 32'(got), 32'h8000);
    cmd(CFG, '0);
    check("R9 cleared after retained read", 32'(got), 32'h0);

    finish_run();
  end
endmodule